// File: doc/BRIEF.md
# Standby Control and Power-Down Sequencer

This block holds an 8-bit control register that tells a chip what to do when the processor asks to power down. It also runs the small state machine that carries out that request. Two bits in the register matter. The deep bit chooses between a light sleep, in which only the processor clock stops, and a full standby, in which the peripheral clocks stop as well. The float bit chooses, for standby only, whether the I/O pins keep their last levels or go to high impedance. The remaining bits read back as fixed constants.

The watchdog's timer-enable signal guards both control bits. While the watchdog runs, software can clear either bit but cannot set it. This keeps a running watchdog from being stranded by a deep power-down. The deep bit is sampled in the same cycle as the one-cycle sleep request, and that value picks the target state. A wake input brings the block back to run mode at the next clock edge. Reset also brings it back to run mode and reloads the register.

Top module: `pdn_sequencer`

## Requirements
- R1: After reset the register reads 0x1F, mode is 00, both clock enables are 1 and both pin outputs are 0. An asynchronous reset during standby restores this state at once.
- R2: While wdt_run is 0, a write stores wr_data bit 7 (deep) and bit 6 (float), and they read back at those positions.
- R3: While wdt_run is 1, a write with bit 7 set leaves a cleared deep bit at 0.
- R4: While wdt_run is 1, a write with bit 6 set leaves a cleared float bit at 0.
- R5: While wdt_run is 1, a write with bit 7 or bit 6 at 0 clears that bit.
- R6: Read bit 5 is always 0 and read bits 4..0 are always 1, whatever was written.
- R7: A sleep_req in run mode with the deep bit at 0 gives mode 01 after the next edge, with cpu_clk_en at 0 and per_clk_en at 1.
- R8: A sleep_req in run mode with the deep bit at 1 gives mode 10 after the next edge, with both clock enables at 0.
- R9: pin_float is 1 only in standby with the float bit at 1, and pin_hold is 1 only in standby with the float bit at 0. The float bit is read live, so a write during standby takes effect.
- R10: wake in sleep or standby gives mode 00 after the next edge. wake asserted together with sleep_req in run mode keeps the block in run mode.
- R11: sleep_req outside run mode has no effect on the mode.
- R12: mode encodes run as 00, sleep as 01 and standby as 10, and never shows 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| wdt_run | input | 1 | Watchdog timer-enable, interlock source |
| sleep_req | input | 1 | One-cycle power-down request from the CPU |
| wake | input | 1 | Interrupt or wake event |
| mode | output | 2 | Current state code |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| pin_float | output | 1 | Drive I/O pins to high impedance |
| pin_hold | output | 1 | Latch I/O pin levels |

## Verification
The hardest case to reach is a sleep request that arrives while the block is already asleep and the deep bit has meanwhile been set. Reaching it needs a write during sleep, followed by a second request. The stimulus table does exactly this, and then checks that the mode stays at sleep instead of moving to standby. A second sequence rewrites the float bit, and then clears it with the watchdog running, all while in standby. This shows that the pin outputs follow the live register and that clearing is always allowed.

// File: rtl/pdn_pkg.sv
package pdn_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'b00,
        ST_SLEEP   = 2'b01,
        ST_STANDBY = 2'b10
    } pdn_state_e;

    typedef struct packed {
        pdn_state_e st;
    } fsm_regs_t;
endpackage

// File: rtl/pdn_ctl_reg.sv
module pdn_ctl_reg #(
    parameter int               REG_W    = 8,
    parameter int               DEEP_BIT = 7,
    parameter int               FLT_BIT  = 6,
    parameter logic [REG_W-1:0] ONE_MASK = 8'h1F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             wdt_run,
    output logic [REG_W-1:0] rd_data,
    output logic             deep,
    output logic             flt
);
    localparam logic [REG_W-1:0] CTRL_MASK = (REG_W'(1) << DEEP_BIT) | (REG_W'(1) << FLT_BIT);

    typedef struct packed {
        logic [REG_W-1:0] ctl;
    } reg_state_t;

    reg_state_t r_d, r_q;
    logic [REG_W-1:0] keep_mask;

    always_comb begin
        r_d = r_q;
        // with the watchdog running a bit may only stay set or clear, never rise
        keep_mask = wdt_run ? r_q.ctl : {REG_W{1'b1}};
        if (wr_en)
            r_d.ctl = wr_data & CTRL_MASK & keep_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = r_q.ctl | ONE_MASK;
    assign deep    = r_q.ctl[DEEP_BIT];
    assign flt     = r_q.ctl[FLT_BIT];

    AST_NO_SET_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdt_run && !deep) |=> !deep); // R3
    AST_NO_SET_FLT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdt_run && !flt) |=> !flt); // R4
    AST_CLEAR_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[DEEP_BIT]) |=> !deep); // R5
endmodule

// File: rtl/pdn_mode_fsm.sv
module pdn_mode_fsm
    import pdn_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake,
    input  logic       deep,
    output pdn_state_e state
);
    fsm_regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            ST_RUN: begin
                if (sleep_req && !wake)
                    s_d.st = deep ? ST_STANDBY : ST_SLEEP;
            end
            ST_SLEEP, ST_STANDBY: begin
                if (wake) s_d.st = ST_RUN;
            end
            default: s_d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_RUN};
        else        s_q <= s_d;
    end

    assign state = s_q.st;

    AST_ENTER_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && !wake && !deep) |=> state == ST_SLEEP); // R7
    AST_ENTER_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && sleep_req && !wake && deep) |=> state == ST_STANDBY); // R8
    AST_WAKE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && wake) |=> state == ST_RUN); // R10
    AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !wake) |=> state == ST_SLEEP); // R11
endmodule

// File: rtl/pdn_outputs.sv
module pdn_outputs
    import pdn_pkg::*;
(
    input  pdn_state_e state,
    input  logic       flt,
    output logic [1:0] mode,
    output logic       cpu_clk_en,
    output logic       per_clk_en,
    output logic       pin_float,
    output logic       pin_hold
);
    logic in_stby;

    always_comb begin
        in_stby    = (state == ST_STANDBY);
        mode       = state;
        cpu_clk_en = (state == ST_RUN);
        per_clk_en = !in_stby;
        pin_float  = in_stby && flt;
        pin_hold   = in_stby && !flt;
    end
endmodule

// File: rtl/pdn_sequencer.sv
module pdn_sequencer
    import pdn_pkg::*;
#(
    parameter int REG_W    = 8,
    parameter int DEEP_BIT = 7,
    parameter int FLT_BIT  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             wdt_run,
    input  logic             sleep_req,
    input  logic             wake,
    output logic [1:0]       mode,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             pin_float,
    output logic             pin_hold
);
    localparam logic [REG_W-1:0] ONE_MASK = REG_W'(8'h1F);

    logic       deep, flt;
    pdn_state_e state;

    pdn_ctl_reg #(
        .REG_W(REG_W), .DEEP_BIT(DEEP_BIT), .FLT_BIT(FLT_BIT), .ONE_MASK(ONE_MASK)
    ) u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wdt_run(wdt_run), .rd_data(rd_data), .deep(deep), .flt(flt)
    );

    pdn_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake(wake),
        .deep(deep), .state(state)
    );

    pdn_outputs u_out (
        .state(state), .flt(flt), .mode(mode), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .pin_float(pin_float), .pin_hold(pin_hold)
    );

    AST_PIN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_float && pin_hold)); // R9
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11); // R12
    AST_CLK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        per_clk_en || !cpu_clk_en); // R8
endmodule

// File: tb/pdn_sequencer_bench.sv
module pdn_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wdt_run = 1'b0;
    logic       sleep_req = 1'b0;
    logic       wake = 1'b0;
    logic [7:0] rd_data;
    logic [1:0] mode;
    logic       cpu_clk_en, per_clk_en, pin_float, pin_hold;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pdn_sequencer u_pdn_sequencer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .wdt_run(wdt_run), .sleep_req(sleep_req),
        .wake(wake), .mode(mode), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .pin_float(pin_float), .pin_hold(pin_hold)
    );

    // {req, wr_en, wr_data, wdt_run, sleep_req, wake, exp_rd, exp_mode, exp_ctl}
    // exp_ctl = {cpu_clk_en, per_clk_en, pin_float, pin_hold}
    localparam int NV = 20;
    localparam logic [29:0] VEC [NV] = '{
        {4'd2,  1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 8'hDF, 2'b00, 4'b1100}, // R2 set both
        {4'd2,  1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h1F, 2'b00, 4'b1100}, // R2 clear
        {4'd3,  1'b1, 8'hC0, 1'b1, 1'b0, 1'b0, 8'h1F, 2'b00, 4'b1100}, // R3 blocked
        {4'd4,  1'b1, 8'h40, 1'b1, 1'b0, 1'b0, 8'h1F, 2'b00, 4'b1100}, // R4 blocked
        {4'd2,  1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 8'hDF, 2'b00, 4'b1100}, // R2
        {4'd5,  1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h1F, 2'b00, 4'b1100}, // R5 clear with wdt
        {4'd2,  1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 8'h9F, 2'b00, 4'b1100}, // R2 deep only
        {4'd6,  1'b1, 8'h3F, 1'b1, 1'b0, 1'b0, 8'h1F, 2'b00, 4'b1100}, // R6 fixed bits, R5
        {4'd6,  1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h1F, 2'b00, 4'b1100}, // R6
        {4'd7,  1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h1F, 2'b01, 4'b0100}, // R7 sleep
        {4'd2,  1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 8'h9F, 2'b01, 4'b0100}, // R2 write while asleep
        {4'd11, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h9F, 2'b01, 4'b0100}, // R11 req ignored
        {4'd10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h9F, 2'b00, 4'b1100}, // R10 wake
        {4'd8,  1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h9F, 2'b10, 4'b0001}, // R8 standby hold
        {4'd9,  1'b1, 8'hC0, 1'b0, 1'b0, 1'b0, 8'hDF, 2'b10, 4'b0010}, // R9 float live
        {4'd10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hDF, 2'b00, 4'b1100}, // R10 wake
        {4'd10, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 8'hDF, 2'b00, 4'b1100}, // R10 wake beats req
        {4'd8,  1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'hDF, 2'b10, 4'b0010}, // R8 standby float
        {4'd9,  1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 8'h1F, 2'b10, 4'b0001}, // R9 hold after clear
        {4'd12, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h1F, 2'b00, 4'b1100}  // R12 back to run
    };

    task automatic check(input int req, input logic [7:0] exp_rd,
                         input logic [1:0] exp_mode, input logic [3:0] exp_ctl);
        logic [3:0] act_ctl;
        act_ctl = {cpu_clk_en, per_clk_en, pin_float, pin_hold};
        total++;
        if (rd_data !== exp_rd || mode !== exp_mode || act_ctl !== exp_ctl) begin
            bad++;
            $display("FAIL R%0d: rd=%h mode=%b ctl=%b expected rd=%h mode=%b ctl=%b",
                     req, rd_data, mode, act_ctl, exp_rd, exp_mode, exp_ctl);
        end
    endtask

    initial begin
        #1;
        check(1, 8'h1F, 2'b00, 4'b1100); // R1 state in reset
        #20;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(1, 8'h1F, 2'b00, 4'b1100); // R1 after release

        for (int i = 0; i < NV; i++) begin
            wr_en     = VEC[i][25];
            wr_data   = VEC[i][24:17];
            wdt_run   = VEC[i][16];
            sleep_req = VEC[i][15];
            wake      = VEC[i][14];
            @(posedge clk); #1;
            wr_en = 1'b0; sleep_req = 1'b0; wake = 1'b0; wdt_run = 1'b0;
            check(int'(VEC[i][29:26]), VEC[i][13:6], VEC[i][5:4], VEC[i][3:0]);
        end

        // R1: reset from standby with float set
        wr_en = 1'b1; wr_data = 8'hC0;
        @(posedge clk); #1;
        wr_en = 1'b0; sleep_req = 1'b1;
        @(posedge clk); #1;
        sleep_req = 1'b0;
        check(8, 8'hDF, 2'b10, 4'b0010); // R8
        rst_n = 1'b0; #1;
        check(1, 8'h1F, 2'b00, 4'b1100); // R1 async reset
        @(posedge clk); #1;
        rst_n = 1'b1;
        sleep_req = 1'b1;
        @(posedge clk); #1;
        sleep_req = 1'b0;
        check(7, 8'h1F, 2'b01, 4'b0100); // R7 deep bit cleared by reset

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog: run hung, expected completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule